// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus interface of a byte-wide NOR flash with an 18-bit address space. Each write cycle reaches it already captured, as one clock of `wrValid` with an address and a data byte. The block follows the multi-write unlock protocol and decides which internal operation to launch: return to array read, identifier read, byte program, whole-array erase, single-sector erase, erase suspend or erase resume. It does not touch the memory array. It emits a one-cycle start pulse with an operation code, and it holds the target address, data byte and sector number for the engine that does the work.

The decoder also reports a two-bit mode: array read, identifier read, busy or erase-suspended. While an operation runs it filters the incoming writes. A program or a whole-array erase ignores every write. A sector erase accepts only a suspend byte, and that request takes effect after a programmable number of cycles. While suspended, only the resume byte is accepted. The engine ends a busy period by pulsing `opDone`. An active-low reset aborts everything and returns the block to array read.

Top module: `flashCmdDecoder`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `mode` is 0 (array read) and `opStart` is 0. A reset during a busy or suspended operation abandons it.
- R2: Outside busy and suspended modes, a write of F0h at any address sets `mode` to 0 and pulses `opStart` with `opKind` 0 (reset). This does not apply as the data write of a program. It also abandons any partly entered sequence.
- R3: The writes AAh at low-12-bit address 555h, then 55h at 2AAh, then 90h at 555h pulse `opKind` 1 and set `mode` to 1 (identifier). Address bits 17..12 are ignored for the unlock compare.
- R4: The writes AAh@555h, 55h@2AAh, A0h@555h and then one write at any address pulse `opKind` 2 (program). `opAddr` and `opData` equal that last write, and `mode` becomes 2 (busy).
- R5: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h pulse `opKind` 3 (whole-array erase), and `mode` becomes 2.
- R6: The same five opening writes followed by 30h at any address pulse `opKind` 4 (sector erase), with `opSector` equal to address bits 17..13 of that write. `mode` becomes 2.
- R7: A write with the wrong address or wrong data at any step of a sequence aborts it with no pulse, and `mode` returns to 0, including from identifier mode.
- R8: In busy mode, every write is ignored: no pulse, and `mode` stays 2. This covers repeated 30h during a sector erase and B0h during a program or whole-array erase. A one-cycle `opDone` returns `mode` to 0. `opDone` is ignored in modes 0, 1 and 3.
- R9: During a sector erase, B0h at any address makes `mode` 3 (suspended) exactly `suspDelay`+1 cycles after the write is taken. It pulses `opKind` 5 in that same cycle. Further B0h writes before then are ignored.
- R10: In suspended mode, only 30h is accepted. It pulses `opKind` 6 (resume), returns `mode` to 2 and keeps `opSector`. Every other write is ignored. Suspend and resume may alternate any number of times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset, also the hardware abort |
| wrValid | input | 1 | One captured write cycle this clock |
| wrAddr | input | 18 | Address of the write |
| wrData | input | 8 | Data byte of the write |
| opDone | input | 1 | Running program or erase has finished |
| suspDelay | input | 16 | Cycles, minus one, from suspend request to suspended |
| opStart | output | 1 | One-cycle operation start pulse |
| opKind | output | 3 | Operation code of the pulse (0 reset … 6 resume) |
| opAddr | output | 18 | Program target address |
| opData | output | 8 | Program data byte |
| opSector | output | 5 | Sector under erase |
| mode | output | 2 | 0 read, 1 identifier, 2 busy, 3 suspended |

## Verification
The bench targets the places where a sequence can be cut short or mistaken for another one:
- A wrong address at the second unlock step. A design that failed to abort here would let a later stray write complete a program.
- Upper address bits set on the unlock writes. A design that compared the full address would never unlock.
- Redundant 30h during an erase. A design that did not ignore it would start a second erase.
- B0h during a program. A design that did not filter it would suspend a program.
- F0h while suspended. A design that honoured it would lose the suspended erase.

The suspend delay is measured cycle by cycle at zero and at a larger count, which exposes a counter that is off by one. Random writes drawn from the protocol bytes then mix partial sequences, aborts and completion pulses against a bench model of the requirements.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_AUTO = 2'd1,
    MODE_BUSY = 2'd2,
    MODE_SUSP = 2'd3
  } devMode_t;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_AUTOSEL = 3'd1,
    OP_PROG    = 3'd2,
    OP_CHIP    = 3'd3,
    OP_SECTOR  = 3'd4,
    OP_SUSPEND = 3'd5,
    OP_RESUME  = 3'd6
  } opKind_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PW, SQ_E1, SQ_E2, SQ_E3
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic latchProg;
    logic latchSector;
    logic suspLoad;
    logic suspTick;
  } ctrlStrobes_t;

  localparam logic [7:0] BYTE_KEY1   = 8'hAA;
  localparam logic [7:0] BYTE_KEY2   = 8'h55;
  localparam logic [7:0] BYTE_IDENT  = 8'h90;
  localparam logic [7:0] BYTE_PROG   = 8'hA0;
  localparam logic [7:0] BYTE_ERASE  = 8'h80;
  localparam logic [7:0] BYTE_CHIP   = 8'h10;
  localparam logic [7:0] BYTE_SECTOR = 8'h30;
  localparam logic [7:0] BYTE_SUSP   = 8'hB0;
  localparam logic [7:0] BYTE_EXIT   = 8'hF0;

endpackage

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flash_cmd_pkg::*;
#(
  parameter int UNLK_W = 12,
  parameter logic [UNLK_W-1:0] KEY_ADDR1 = 12'h555,
  parameter logic [UNLK_W-1:0] KEY_ADDR2 = 12'h2AA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [UNLK_W-1:0] unlkAddr,
  input  logic [7:0]        wrData,
  input  logic              opDone,
  input  logic              suspZero,
  output ctrlStrobes_t      strb,
  output logic              opStart,
  output opKind_t           opKind,
  output devMode_t          mode
);

  seqState_t seq, seqN;
  devMode_t  modeN;
  opKind_t   busyOp, busyN, kindN;
  logic      suspPend, pendN, startN;

  logic atKey1, atKey2;
  assign atKey1 = (unlkAddr == KEY_ADDR1);
  assign atKey2 = (unlkAddr == KEY_ADDR2);

  always_comb begin
    seqN   = seq;
    modeN  = mode;
    busyN  = busyOp;
    pendN  = suspPend;
    startN = 1'b0;
    kindN  = opKind;
    strb   = '0;
    unique case (mode)
      MODE_BUSY: begin
        if (opDone) begin
          modeN = MODE_READ;
          pendN = 1'b0;
          seqN  = SQ_IDLE;
        end else if (suspPend) begin
          if (suspZero) begin
            modeN  = MODE_SUSP;
            pendN  = 1'b0;
            startN = 1'b1;
            kindN  = OP_SUSPEND;
          end else begin
            strb.suspTick = 1'b1;
          end
        end else if (wrValid && busyOp == OP_SECTOR && wrData == BYTE_SUSP) begin
          pendN         = 1'b1;
          strb.suspLoad = 1'b1;
        end
      end
      MODE_SUSP: begin
        if (wrValid && wrData == BYTE_SECTOR) begin
          modeN  = MODE_BUSY;
          startN = 1'b1;
          kindN  = OP_RESUME;
        end
      end
      default: begin
        if (wrValid) begin
          if (seq != SQ_PW && wrData == BYTE_EXIT) begin
            modeN  = MODE_READ;
            seqN   = SQ_IDLE;
            startN = 1'b1;
            kindN  = OP_RESET;
          end else begin
            // abort is the default outcome of every step
            seqN  = SQ_IDLE;
            modeN = MODE_READ;
            unique case (seq)
              SQ_IDLE: if (wrData == BYTE_KEY1 && atKey1) begin seqN = SQ_U1; modeN = mode; end
              SQ_U1:   if (wrData == BYTE_KEY2 && atKey2) begin seqN = SQ_U2; modeN = mode; end
              SQ_U2: begin
                if (atKey1 && wrData == BYTE_IDENT) begin
                  modeN  = MODE_AUTO;
                  startN = 1'b1;
                  kindN  = OP_AUTOSEL;
                end else if (atKey1 && wrData == BYTE_PROG) begin
                  seqN = SQ_PW; modeN = mode;
                end else if (atKey1 && wrData == BYTE_ERASE) begin
                  seqN = SQ_E1; modeN = mode;
                end
              end
              SQ_PW: begin
                modeN          = MODE_BUSY;
                busyN          = OP_PROG;
                startN         = 1'b1;
                kindN          = OP_PROG;
                strb.latchProg = 1'b1;
              end
              SQ_E1: if (wrData == BYTE_KEY1 && atKey1) begin seqN = SQ_E2; modeN = mode; end
              SQ_E2: if (wrData == BYTE_KEY2 && atKey2) begin seqN = SQ_E3; modeN = mode; end
              SQ_E3: begin
                if (atKey1 && wrData == BYTE_CHIP) begin
                  modeN  = MODE_BUSY;
                  busyN  = OP_CHIP;
                  startN = 1'b1;
                  kindN  = OP_CHIP;
                end else if (wrData == BYTE_SECTOR) begin
                  modeN            = MODE_BUSY;
                  busyN            = OP_SECTOR;
                  startN           = 1'b1;
                  kindN            = OP_SECTOR;
                  strb.latchSector = 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seq      <= SQ_IDLE;
      mode     <= MODE_READ;
      busyOp   <= OP_RESET;
      suspPend <= 1'b0;
      opStart  <= 1'b0;
      opKind   <= OP_RESET;
    end else begin
      seq      <= seqN;
      mode     <= modeN;
      busyOp   <= busyN;
      suspPend <= pendN;
      opStart  <= startN;
      opKind   <= kindN;
    end
  end

  // R8: a running program swallows every write
  p_prog_deaf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BUSY && busyOp == OP_PROG && !opDone) |=> (mode == MODE_BUSY && !opStart));

  // R10: suspended state is left only by the resume byte
  p_susp_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SUSP && !(wrValid && wrData == BYTE_SECTOR)) |=> (mode == MODE_SUSP && !opStart));

  // R10: resume is only ever issued out of suspension
  p_resume_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && opKind == OP_RESUME) |-> ($past(mode) == MODE_SUSP));

  // R9: entering suspension is announced by the suspend pulse
  p_susp_entry_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mode == MODE_SUSP) |-> (opStart && opKind == OP_SUSPEND));

endmodule

// File: rtl/flashCmdPath.sv
module flashCmdPath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int SECT_LSB = 13,
  parameter int CNT_W    = 16,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [CNT_W-1:0]  suspDelay,
  output logic              suspZero,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output logic [SECT_W-1:0] opSector
);

  logic [CNT_W-1:0] suspCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr   <= '0;
      opData   <= '0;
      opSector <= '0;
      suspCnt  <= '0;
    end else begin
      if (strb.latchProg) begin
        opAddr <= wrAddr;
        opData <= wrData;
      end
      if (strb.latchSector)
        opSector <= wrAddr[ADDR_W-1:SECT_LSB];
      if (strb.suspLoad)
        suspCnt <= suspDelay;
      else if (strb.suspTick && suspCnt != '0)
        suspCnt <= suspCnt - 1'b1;
    end
  end

  assign suspZero = (suspCnt == '0);

  // R10: the erased sector survives suspend and resume
  p_sector_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchSector |=> $stable(opSector));

endmodule

// File: rtl/flashCmdDecoder.sv
module flashCmdDecoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int SECT_LSB = 13,
  parameter int CNT_W    = 16,
  parameter int UNLK_W   = 12,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              opDone,
  input  logic [CNT_W-1:0]  suspDelay,
  output logic              opStart,
  output logic [2:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData,
  output logic [SECT_W-1:0] opSector,
  output logic [1:0]        mode
);

  ctrlStrobes_t strb;
  logic         suspZero;
  opKind_t      kindQ;
  devMode_t     modeQ;

  flashCmdCtrl #(.UNLK_W(UNLK_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid),
    .unlkAddr(wrAddr[UNLK_W-1:0]), .wrData(wrData), .opDone(opDone),
    .suspZero(suspZero), .strb(strb), .opStart(opStart),
    .opKind(kindQ), .mode(modeQ)
  );

  flashCmdPath #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .suspDelay(suspDelay), .suspZero(suspZero), .opAddr(opAddr),
    .opData(opData), .opSector(opSector)
  );

  assign opKind = kindQ;
  assign mode   = modeQ;

  // R4: program pulse carries the preceding write
  p_prog_payload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && opKind == OP_PROG) |-> (opAddr == $past(wrAddr) && opData == $past(wrData)));

  // R6: sector number taken from the erase write's upper address bits
  p_sector_field_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && opKind == OP_SECTOR) |-> (opSector == $past(wrAddr[ADDR_W-1:SECT_LSB])));

endmodule

// File: tb/tb_flashCmdDecoder.sv
module tb_flashCmdDecoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [17:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        opDone = 1'b0;
  logic [15:0] suspDelay = 16'd3;
  logic        opStart;
  logic [2:0]  opKind;
  logic [17:0] opAddr;
  logic [7:0]  opData;
  logic [4:0]  opSector;
  logic [1:0]  mode;

  flashCmdDecoder dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .opDone(opDone), .suspDelay(suspDelay), .opStart(opStart), .opKind(opKind),
    .opAddr(opAddr), .opData(opData), .opSector(opSector), .mode(mode)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  // bench model of the requirements
  int          mMode, mSeq, mBusy;
  bit          mPend;
  bit          expStart;
  int          expKind;
  logic [17:0] expAddr;
  logic [7:0]  expData;
  logic [4:0]  expSect;
  string       req;

  task automatic check(input bit ok, input string r, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic bit key1(input logic [17:0] a); return a[11:0] == 12'h555; endfunction
  function automatic bit key2(input logic [17:0] a); return a[11:0] == 12'h2AA; endfunction

  function automatic void modelWrite(input logic [17:0] a, input logic [7:0] d);
    expStart = 1'b0;
    req = "R7";
    if (mMode == 2) begin
      req = "R8";
      if (mBusy == 4 && d == 8'hB0) begin mPend = 1'b1; req = "R9"; end
    end else if (mMode == 3) begin
      req = "R10";
      if (d == 8'h30) begin mMode = 2; expStart = 1'b1; expKind = 6; end
    end else if (mSeq != 3 && d == 8'hF0) begin
      req = "R2"; mMode = 0; mSeq = 0; expStart = 1'b1; expKind = 0;
    end else begin
      int nxt;
      nxt = -1;
      case (mSeq)
        0: if (d == 8'hAA && key1(a)) nxt = 1;
        1: if (d == 8'h55 && key2(a)) nxt = 2;
        2: if (key1(a) && d == 8'h90) begin
             req = "R3"; nxt = 0; mMode = 1; expStart = 1'b1; expKind = 1;
           end else if (key1(a) && d == 8'hA0) nxt = 3;
           else if (key1(a) && d == 8'h80) nxt = 4;
        3: begin
             req = "R4"; nxt = 0; mMode = 2; mBusy = 2; expStart = 1'b1; expKind = 2;
             expAddr = a; expData = d;
           end
        4: if (d == 8'hAA && key1(a)) nxt = 5;
        5: if (d == 8'h55 && key2(a)) nxt = 6;
        6: if (key1(a) && d == 8'h10) begin
             req = "R5"; nxt = 0; mMode = 2; mBusy = 3; expStart = 1'b1; expKind = 3;
           end else if (d == 8'h30) begin
             req = "R6"; nxt = 0; mMode = 2; mBusy = 4; expStart = 1'b1; expKind = 4;
             expSect = a[17:13];
           end
        default: ;
      endcase
      if (nxt < 0) begin mSeq = 0; mMode = 0; end
      else mSeq = nxt;
    end
  endfunction

  task automatic waitSuspend();
    for (int n = 1; n <= int'(suspDelay) + 1; n++) begin
      @(negedge clk);
      if (n <= int'(suspDelay))
        check(mode == 2'd2 && !opStart, "R9 early", {mode, opStart}, 2 << 1);
      else
        check(mode == 2'd3 && opStart && opKind == 3'd5, "R9 entry",
              {mode, opStart, opKind}, {2'd3, 1'b1, 3'd5});
    end
    mMode = 3;
    mPend = 1'b0;
  endtask

  task automatic doWrite(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    modelWrite(a, d);
    @(negedge clk);
    wrValid = 1'b0;
    check(opStart == expStart, req, opStart, expStart);
    if (expStart) check(opKind == expKind[2:0], req, opKind, expKind);
    if (expStart && expKind == 2) begin
      check(opAddr == expAddr, "R4 addr", opAddr, expAddr);
      check(opData == expData, "R4 data", opData, expData);
    end
    if (expStart && (expKind == 4 || expKind == 6))
      check(opSector == expSect, "R6 sector", opSector, expSect);
    check(mode == mMode[1:0], req, mode, mMode);
    if (mPend) waitSuspend();
  endtask

  task automatic pulseDone();
    @(negedge clk);
    opDone = 1'b1;
    if (mMode == 2) begin mMode = 0; mSeq = 0; end
    @(negedge clk);
    opDone = 1'b0;
    check(mode == mMode[1:0] && !opStart, "R8 done", mode, mMode);
  endtask

  task automatic hwReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(mode == 2'd0 && !opStart, "R1 held", mode, 0);
    @(negedge clk); rstN = 1'b1;
    mMode = 0; mSeq = 0; mPend = 1'b0;
    @(negedge clk);
    check(mode == 2'd0 && !opStart, "R1 after", mode, 0);
  endtask

  function automatic logic [17:0] hi(input logic [11:0] lo);
    return {6'($urandom_range(0, 63)), lo};
  endfunction

  task automatic unlock2();
    doWrite(hi(12'h555), 8'hAA);
    doWrite(hi(12'h2AA), 8'h55);
  endtask

  task automatic eraseHead();
    unlock2();
    doWrite(hi(12'h555), 8'h80);
    unlock2();
  endtask

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mMode = 0; mSeq = 0; mBusy = 0; mPend = 1'b0;
    expKind = 0; expAddr = '0; expData = '0; expSect = '0;
    hwReset();                                              // R1

    // R3 identifier with upper bits set, then R2 exit
    doWrite(18'h3F555, 8'hAA); doWrite(18'h152AA, 8'h55); doWrite(18'h2A555, 8'h90);
    doWrite(18'h01234, 8'hF0);

    // R4 program, R8 writes ignored, B0 ignored during program (R9)
    unlock2(); doWrite(hi(12'h555), 8'hA0); doWrite(18'h12345, 8'h5A);
    unlock2(); doWrite(18'h00000, 8'hB0); doWrite(18'h00000, 8'hF0);
    pulseDone();

    // R5 whole-array erase, B0 ignored
    eraseHead(); doWrite(18'h10555, 8'h10);
    doWrite(18'h0, 8'hB0); doWrite(18'h0, 8'h30);
    pulseDone();

    // R6 sector erase, extra 30h ignored, R9 suspend timing, R10 filters
    suspDelay = 16'd5;
    eraseHead(); doWrite(18'h2A000, 8'h30);
    doWrite(18'h3C000, 8'h30);
    doWrite(18'h00000, 8'hB0);
    doWrite(18'h00000, 8'hB0); doWrite(18'h00000, 8'hF0); doWrite(18'h00555, 8'hAA);
    pulseDone();                                            // ignored while suspended
    doWrite(18'h3FFFF, 8'h30);                              // R10 resume, sector kept
    suspDelay = 16'd0;
    doWrite(18'h00000, 8'hB0);
    doWrite(18'h00000, 8'h30);
    pulseDone();

    // R7 aborts
    doWrite(18'h00555, 8'hAA); doWrite(18'h00555, 8'h55);
    doWrite(18'h002AA, 8'h55);
    unlock2(); doWrite(18'h00555, 8'h90);
    doWrite(18'h00123, 8'h77);
    eraseHead(); doWrite(18'h00555, 8'hA0);

    // R1 reset during sector erase
    eraseHead(); doWrite(18'h06000, 8'h30);
    hwReset();

    // random mix
    suspDelay = 16'd3;
    for (int it = 0; it < 500; it++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r <= 5) begin
        logic [7:0] d;
        logic [17:0] a;
        case ($urandom_range(0, 9))
          0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'hA0; 3: d = 8'h80; 4: d = 8'h90;
          5: d = 8'h10; 6: d = 8'h30; 7: d = 8'hB0; 8: d = 8'hF0;
          default: d = 8'($urandom);
        endcase
        case ($urandom_range(0, 2))
          0: a = hi(12'h555); 1: a = hi(12'h2AA); default: a = 18'($urandom);
        endcase
        doWrite(a, d);
      end else if (r == 6) begin
        case ($urandom_range(0, 3))
          0: begin unlock2(); doWrite(hi(12'h555), 8'h90); end
          1: begin unlock2(); doWrite(hi(12'h555), 8'hA0); doWrite(18'($urandom), 8'($urandom)); end
          2: begin eraseHead(); doWrite(hi(12'h555), 8'h10); end
          default: begin eraseHead(); doWrite(18'($urandom), 8'h30); end
        endcase
      end else if (r == 7) begin
        pulseDone();
      end else if (r == 8) begin
        doWrite(18'($urandom), 8'hF0);
      end else begin
        doWrite(18'($urandom), (mMode == 3) ? 8'h30 : 8'hB0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule